// File: doc/BRIEF.md
# Frame Receive DMA (32-bit stream to 256-bit memory bursts)

This block sits between a serial-storage link core and system memory. The link core hands over each received frame as a stream of 32-bit words. The first and last words of a frame are flagged. The block reads the type code in the first word and sends the frame to one of two memory areas. Frames whose type marks them as data go to the data area. Every other frame goes to the non-data area. Words are gathered eight at a time into 256-bit beats and placed in a beat FIFO. A write engine drains the FIFO to memory, using only full AXI4 write bursts of sixteen beats (512 bytes).

The input is valid/ready. A word moves on a rising clock edge where `s_valid` and `s_ready` are both high. The source must hold the word and its markers stable until that edge. The block drops `s_ready` while its FIFO is nearly full. It also drops `s_ready` while it pads the end of a frame. Software first loads the two area base addresses, then pulses `rearm`. After that, each frame lands at the next free 512-byte slot of its area. When the last burst of a frame has been acknowledged on the write-response channel, `done` pulses. At that point `rx_count` and `rx_is_data` describe that frame.

Top module: `rxdma_frame_rx`

## Requirements
- R1: A frame goes to the data area when bits [7:0] of its first word equal 0x46, and to the non-data area otherwise. The same byte in later words of the frame has no effect on where it goes.
- R2: Word k of a frame, header included, is written in beat k/8 of the frame at bits [32*(k mod 8)+31 : 32*(k mod 8)].
- R3: Every frame fills a whole number of 16-beat bursts: ceil(length/128) bursts. All beat lanes after the last word of the frame are zero.
- R4: Every burst has AWLEN=15, AWSIZE=5, AWBURST=1 (incrementing) and WSTRB all ones. WLAST is high on the 16th beat only. A valid address or data beat holds its value until it is accepted.
- R5: A write address is issued only when the FIFO holds at least 16 beats.
- R6: Within each area, the burst address starts at that area's base and steps by 512 per burst. A `rearm` pulse reloads both areas' next address from `data_base` and `other_base`.
- R7: `s_ready` is low while the FIFO holds DEPTH-2 or more beats and while a frame tail is being padded. No word is lost when the memory side stalls, and the FIFO never overflows.
- R8: `rx_count` becomes 1 on the first word of a frame and counts up by one on each later word. It therefore includes the header. `rx_is_data` records the type decision of the latest frame. `rearm` clears both. Both read 0 after reset.
- R9: `done` pulses for one cycle, the cycle after the write response of a frame's last burst is accepted. It does not pulse for earlier bursts of the same frame.
- R10: Input words move only on a cycle where `s_valid` and `s_ready` are both high. Gaps in `s_valid` do not change the stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rearm | input | 1 | Reload area addresses, clear status |
| data_base | input | 32 | Base address of the data area |
| other_base | input | 32 | Base address of the non-data area |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Block can accept a word |
| s_data | input | 32 | Input word |
| s_first | input | 1 | Word is the frame header |
| s_last | input | 1 | Word ends the frame |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address accepted |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_wdata | output | 256 | Write data beat |
| m_wstrb | output | 32 | Byte enables |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |
| rx_count | output | 24 | Words received in the latest frame |
| rx_is_data | output | 1 | Latest frame was a data frame |
| done | output | 1 | Frame fully written |

## Verification
The hard case is a beat being pushed by the packer in the same cycle that the write engine pops one, while the FIFO level sits at the nearly-full threshold. This is where an off-by-one in the fill level either loses a word or stalls the input for good. The bench forces it in two ways. It throttles WREADY during long frames. It also holds AWREADY low until the input stalls and then releases it. Each case is judged by the input stalling, by every lane of every written beat matching the word pattern the bench expects, and by the FIFO overflow property.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int WORD_W          = 32;
  localparam int BEAT_W          = 256;
  localparam int WORDS_PER_BEAT  = BEAT_W / WORD_W;
  localparam int BEAT_BYTES      = BEAT_W / 8;
  localparam logic [7:0] DATA_FRAME_CODE = 8'h46;

  typedef struct packed {
    logic is_data;
    logic frame_end;
  } beat_tag_t;

  localparam int TAG_W = $bits(beat_tag_t);

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_ADDR,
    WR_DATA,
    WR_RESP
  } wr_state_e;
endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer
  import rxdma_pkg::*;
#(
  parameter int BURST_BEATS = 16,
  parameter int CNT_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rearm,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_first,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              fifo_af,
  input  logic              fifo_full,
  output logic              push,
  output logic [BEAT_W-1:0] push_beat,
  output beat_tag_t         push_tag,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_is_data
);
  localparam int LANE_W = $clog2(WORDS_PER_BEAT);
  localparam int BIDX_W = $clog2(BURST_BEATS);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORDS_PER_BEAT - 1);
  localparam logic [BIDX_W-1:0] LAST_BIDX = BIDX_W'(BURST_BEATS - 1);

  logic [BEAT_W-1:0] buf_q;
  logic [LANE_W-1:0] lane_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              padding_q;
  logic              cur_data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              isdata_q;

  logic              take;
  logic              word_is_data;
  logic              last_of_burst;
  logic [BEAT_W-1:0] merged;

  assign s_ready       = !padding_q && !fifo_af;
  assign take          = s_valid && s_ready;
  assign word_is_data  = s_first ? (s_data[7:0] == DATA_FRAME_CODE) : cur_data_q;
  assign last_of_burst = (bidx_q == LAST_BIDX);
  assign merged        = buf_q | ({{(BEAT_W-WORD_W){1'b0}}, s_data} << (int'(lane_q) * WORD_W));

  always_comb begin
    push      = 1'b0;
    push_beat = '0;
    push_tag  = '{is_data: cur_data_q, frame_end: last_of_burst};
    if (padding_q) begin
      push = !fifo_full;
    end else if (take && (lane_q == LAST_LANE || s_last)) begin
      push      = 1'b1;
      push_beat = merged;
      push_tag  = '{is_data: word_is_data, frame_end: s_last && last_of_burst};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q      <= '0;
      lane_q     <= '0;
      bidx_q     <= '0;
      padding_q  <= 1'b0;
      cur_data_q <= 1'b0;
    end else if (padding_q) begin
      if (push) begin
        bidx_q <= bidx_q + BIDX_W'(1);
        if (last_of_burst) padding_q <= 1'b0;
      end
    end else if (take) begin
      cur_data_q <= word_is_data;
      if (push) begin
        buf_q  <= '0;
        lane_q <= '0;
        bidx_q <= bidx_q + BIDX_W'(1);
        if (s_last && !last_of_burst) padding_q <= 1'b1;
      end else begin
        buf_q  <= merged;
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rearm) begin
      cnt_q    <= '0;
      isdata_q <= 1'b0;
    end else if (take) begin
      if (s_first) begin
        cnt_q    <= CNT_W'(1);
        isdata_q <= word_is_data;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign rx_count   = cnt_q;
  assign rx_is_data = isdata_q;

  // R8: a continuation word advances the count by exactly one
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !s_first && !rearm) |=> (rx_count == $past(rx_count) + CNT_W'(1)));

  // R7: no word is accepted while the tail is being padded
  p_pad_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (padding_q && s_valid) |-> !take);
endmodule

// File: rtl/rxdma_beat_fifo.sv
module rxdma_beat_fifo #(
  parameter int WIDTH     = 258,
  parameter int DEPTH     = 32,
  parameter int AF_MARGIN = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             almost_full
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout        = mem[rd_ptr_q];
  assign count       = cnt_q;
  assign full        = (cnt_q == CNT_W'(DEPTH));
  assign almost_full = (cnt_q >= CNT_W'(DEPTH - AF_MARGIN));

  // R7: the storage is never written past its depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < CNT_W'(DEPTH)));

  // R5: the write side never drains an empty store
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/rxdma_burst_writer.sv
module rxdma_burst_writer
  import rxdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_BEATS = 16,
  parameter int FCNT_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rearm,
  input  logic [ADDR_W-1:0]     data_base,
  input  logic [ADDR_W-1:0]     other_base,
  input  logic [FCNT_W-1:0]     fifo_count,
  input  logic [BEAT_W-1:0]     head_beat,
  input  beat_tag_t             head_tag,
  output logic                  pop,
  output logic                  awvalid,
  input  logic                  awready,
  output logic [ADDR_W-1:0]     awaddr,
  output logic [7:0]            awlen,
  output logic [2:0]            awsize,
  output logic [1:0]            awburst,
  output logic                  wvalid,
  input  logic                  wready,
  output logic [BEAT_W-1:0]     wdata,
  output logic [BEAT_W/8-1:0]   wstrb,
  output logic                  wlast,
  input  logic                  bvalid,
  output logic                  bready,
  output logic                  done
);
  localparam int BCNT_W = $clog2(BURST_BEATS);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BEATS * BEAT_BYTES);

  wr_state_e         state_q;
  logic [BCNT_W-1:0] beat_q;
  logic              burst_data_q;
  logic              end_q;
  logic              done_q;
  logic [ADDR_W-1:0] data_ptr_q, other_ptr_q;

  assign awvalid = (state_q == WR_ADDR);
  assign awaddr  = burst_data_q ? data_ptr_q : other_ptr_q;
  assign awlen   = 8'(BURST_BEATS - 1);
  assign awsize  = 3'($clog2(BEAT_BYTES));
  assign awburst = 2'b01;
  assign wvalid  = (state_q == WR_DATA);
  assign wdata   = head_beat;
  assign wstrb   = '1;
  assign wlast   = (beat_q == BCNT_W'(BURST_BEATS - 1));
  assign pop     = wvalid && wready;
  assign bready  = (state_q == WR_RESP);
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= WR_IDLE;
      beat_q       <= '0;
      burst_data_q <= 1'b0;
      end_q        <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WR_IDLE: if (fifo_count >= FCNT_W'(BURST_BEATS)) begin
          burst_data_q <= head_tag.is_data;
          state_q      <= WR_ADDR;
        end
        WR_ADDR: if (awready) state_q <= WR_DATA;
        WR_DATA: if (pop) begin
          beat_q <= beat_q + BCNT_W'(1);
          if (wlast) begin
            end_q   <= head_tag.frame_end;
            beat_q  <= '0;
            state_q <= WR_RESP;
          end
        end
        WR_RESP: if (bvalid) begin
          done_q  <= end_q;
          state_q <= WR_IDLE;
        end
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_ptr_q  <= '0;
      other_ptr_q <= '0;
    end else if (rearm) begin
      data_ptr_q  <= data_base;
      other_ptr_q <= other_base;
    end else if (awvalid && awready) begin
      if (burst_data_q) data_ptr_q  <= data_ptr_q + STEP;
      else              other_ptr_q <= other_ptr_q + STEP;
    end
  end

  // R5: an address goes out only with a whole burst stored
  p_aw_full_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (fifo_count >= FCNT_W'(BURST_BEATS)));

  // R4: a pending address holds until taken
  p_aw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !awready && !rearm) |=> (awvalid && $stable(awaddr)));

  // R4: data is not offered past the final beat of a burst
  p_burst_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && wready && wlast) |=> !wvalid);

  // R4: a pending data beat holds until taken
  p_w_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wdata)));
endmodule

// File: rtl/rxdma_frame_rx.sv
module rxdma_frame_rx
  import rxdma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int FIFO_DEPTH  = 32,
  parameter int BURST_BEATS = 16,
  parameter int AF_MARGIN   = 2,
  parameter int CNT_W       = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rearm,
  input  logic [ADDR_W-1:0]    data_base,
  input  logic [ADDR_W-1:0]    other_base,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [31:0]          s_data,
  input  logic                 s_first,
  input  logic                 s_last,
  output logic                 m_awvalid,
  input  logic                 m_awready,
  output logic [ADDR_W-1:0]    m_awaddr,
  output logic [7:0]           m_awlen,
  output logic [2:0]           m_awsize,
  output logic [1:0]           m_awburst,
  output logic                 m_wvalid,
  input  logic                 m_wready,
  output logic [255:0]         m_wdata,
  output logic [31:0]          m_wstrb,
  output logic                 m_wlast,
  input  logic                 m_bvalid,
  output logic                 m_bready,
  output logic [CNT_W-1:0]     rx_count,
  output logic                 rx_is_data,
  output logic                 done
);
  localparam int ENTRY_W = BEAT_W + TAG_W;
  localparam int FCNT_W  = $clog2(FIFO_DEPTH + 1);

  logic              push, pop, fifo_full, fifo_af;
  logic [BEAT_W-1:0] push_beat;
  beat_tag_t         push_tag, head_tag;
  logic [ENTRY_W-1:0] head_entry;
  logic [FCNT_W-1:0] fifo_count;

  rxdma_packer #(.BURST_BEATS(BURST_BEATS), .CNT_W(CNT_W)) packer_i (
    .clk(clk), .rst_n(rst_n), .rearm(rearm),
    .s_valid(s_valid), .s_data(s_data), .s_first(s_first), .s_last(s_last),
    .s_ready(s_ready), .fifo_af(fifo_af), .fifo_full(fifo_full),
    .push(push), .push_beat(push_beat), .push_tag(push_tag),
    .rx_count(rx_count), .rx_is_data(rx_is_data)
  );

  rxdma_beat_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH), .AF_MARGIN(AF_MARGIN)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din({push_tag, push_beat}),
    .pop(pop), .dout(head_entry),
    .count(fifo_count), .full(fifo_full), .almost_full(fifo_af)
  );

  assign head_tag = beat_tag_t'(head_entry[ENTRY_W-1 -: TAG_W]);

  rxdma_burst_writer #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS), .FCNT_W(FCNT_W)) writer_i (
    .clk(clk), .rst_n(rst_n), .rearm(rearm),
    .data_base(data_base), .other_base(other_base),
    .fifo_count(fifo_count), .head_beat(head_entry[BEAT_W-1:0]), .head_tag(head_tag),
    .pop(pop),
    .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr),
    .awlen(m_awlen), .awsize(m_awsize), .awburst(m_awburst),
    .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata), .wstrb(m_wstrb), .wlast(m_wlast),
    .bvalid(m_bvalid), .bready(m_bready), .done(done)
  );

  // R9: completion follows an accepted write response
  p_done_after_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(m_bvalid && m_bready));
endmodule

// File: tb/rxdma_frame_rx_tb_top.sv
module rxdma_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DATA_BASE  = 32'h1000_0000;
  localparam logic [31:0] OTHER_BASE = 32'h2000_0000;
  localparam int CAP = 1024;
  // each entry: {type code[7:0], length in words[15:0]}
  localparam logic [23:0] VECS [8] = '{
    24'h46_0001, 24'h34_0005, 24'h46_0008, 24'h46_0080,
    24'h27_0081, 24'h46_012C, 24'h39_0014, 24'h46_03E8 };

  logic clk = 0, rst_n = 0, rearm = 0;
  logic s_valid = 0, s_first = 0, s_last = 0;
  logic [31:0] s_data = '0;
  logic s_ready;
  logic m_awvalid, m_wvalid, m_wlast, m_bready, rx_is_data, done;
  logic [31:0] m_awaddr, m_wstrb;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst;
  logic [255:0] m_wdata;
  logic [23:0] rx_count;
  logic aw_hold = 0, throttle = 0, bvalid_q = 0;
  logic [31:0] cyc_q = '0;
  int n_aw = 0, n_w = 0, n_done = 0, bad_aw = 0, bad_w = 0;
  logic [31:0] cap_addr [CAP];
  logic [255:0] cap_data [CAP];
  int n_chk = 0, n_fail = 0;
  logic [31:0] dptr, optr;
  int base_aw, base_w, base_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire m_awready = !aw_hold;
  wire m_wready  = !throttle || (cyc_q[1:0] != 2'b00);

  rxdma_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rearm(rearm),
    .data_base(DATA_BASE), .other_base(OTHER_BASE),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_first(s_first), .s_last(s_last),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
    .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_bvalid(bvalid_q), .m_bready(m_bready),
    .rx_count(rx_count), .rx_is_data(rx_is_data), .done(done)
  );

  // memory-side model: capture bursts, answer with one response per burst
  always_ff @(posedge clk) begin
    cyc_q <= cyc_q + 1;
    if (m_awvalid && m_awready) begin
      cap_addr[n_aw % CAP] <= m_awaddr;
      n_aw <= n_aw + 1;
      if (m_awlen != 8'd15 || m_awsize != 3'd5 || m_awburst != 2'b01) bad_aw <= bad_aw + 1;
    end
    if (m_wvalid && m_wready) begin
      cap_data[n_w % CAP] <= m_wdata;
      n_w <= n_w + 1;
      if (m_wstrb != '1 || m_wlast != ((n_w % 16) == 15)) bad_w <= bad_w + 1;
      if (m_wlast) bvalid_q <= 1'b1;
    end
    if (bvalid_q && m_bready) bvalid_q <= 1'b0;
    if (done) n_done <= n_done + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(input int f, input logic [7:0] typ, input int i);
    if (i == 0) return {8'(f), 16'h00A5, typ};
    return {8'(f), 24'(i)};
  endfunction

  task automatic send_frame(input int f, input logic [7:0] typ, input int len);
    for (int i = 0; i < len; i++) begin
      bit acc = 0;
      if (f % 2 == 1 && i % 7 == 3) begin
        @(negedge clk); s_valid = 0;   // R10: idle gap inside the frame
      end
      @(negedge clk);
      s_valid = 1; s_data = word_of(f, typ, i);
      s_first = (i == 0); s_last = (i == len - 1);
      while (!acc) begin
        #1 acc = s_ready;
        @(posedge clk);
        if (!acc) @(negedge clk);
      end
    end
    @(negedge clk);
    s_valid = 0; s_first = 0; s_last = 0;
  endtask

  task automatic mark();
    base_aw = n_aw; base_w = n_w; base_done = n_done;
  endtask

  task automatic check_frame(input int f, input logic [7:0] typ, input int len);
    int nb, bad_addr, bad_dat, t;
    logic [31:0] ptr, eaddr, first_addr;
    bit isd;
    isd = (typ == 8'h46);
    nb = (len + 127) / 128;
    t = 0;
    while (n_done == base_done && t < 20000) begin @(negedge clk); t++; end
    repeat (30) @(negedge clk);
    chk(n_done == base_done + 1, "R9 one done per frame", n_done - base_done, 1);
    chk(rx_count == 24'(len), "R8 word count", rx_count, len);
    chk(rx_is_data == isd, "R8 type flag", rx_is_data, isd);
    chk(n_aw - base_aw == nb, "R3 burst count", n_aw - base_aw, nb);
    ptr = isd ? dptr : optr;
    bad_addr = 0;
    first_addr = cap_addr[base_aw % CAP];
    for (int b = 0; b < nb; b++) begin
      eaddr = ptr + 32'(512 * b);
      if (cap_addr[(base_aw + b) % CAP] != eaddr) bad_addr++;
    end
    chk(bad_addr == 0, "R1/R6 burst address", first_addr, ptr);
    bad_dat = 0;
    for (int b = 0; b < nb * 16; b++) begin
      for (int k = 0; k < 8; k++) begin
        int idx = b * 8 + k;
        logic [31:0] ew = (idx < len) ? word_of(f, typ, idx) : 32'h0;
        if (cap_data[(base_w + b) % CAP][k*32 +: 32] != ew) bad_dat++;
      end
    end
    chk(bad_dat == 0, "R2/R3/R10 beat contents", bad_dat, 0);
    chk(bad_aw == 0 && bad_w == 0, "R4 burst form", bad_aw + bad_w, 0);
    if (isd) dptr = dptr + 32'(512 * nb); else optr = optr + 32'(512 * nb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 run did not complete actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state
    chk(s_ready == 1, "R7 ready out of reset", s_ready, 1);
    chk(m_awvalid == 0 && m_wvalid == 0, "R5 bus idle in reset", {m_awvalid, m_wvalid}, 0);
    chk(rx_count == 0 && done == 0, "R8 status in reset", rx_count, 0);
    rst_n = 1;
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
    dptr = DATA_BASE; optr = OTHER_BASE;

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] typ = VECS[v][23:16];
      int len = int'(VECS[v][15:0]);
      throttle = (len >= 128);
      mark();
      send_frame(v + 1, typ, len);
      check_frame(v + 1, typ, len);
    end
    throttle = 0;

    // R7: memory stalled, input must stall, nothing lost after release
    aw_hold = 1;
    mark();
    fork
      send_frame(20, 8'h46, 600);
    join_none
    repeat (600) @(negedge clk);
    chk(s_ready == 0, "R7 input stalled when store nearly full", s_ready, 0);
    chk(m_awvalid == 1, "R5 address pending with full burst stored", m_awvalid, 1);
    aw_hold = 0;
    throttle = 1;
    check_frame(20, 8'h46, 600);
    throttle = 0;

    // R6/R8: rearm rebases addresses and clears status
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
    chk(rx_count == 0 && rx_is_data == 0, "R8 cleared by rearm", rx_count, 0);
    dptr = DATA_BASE; optr = OTHER_BASE;
    mark();
    send_frame(21, 8'h46, 3);
    check_frame(21, 8'h46, 3);
    mark();
    send_frame(22, 8'h5F, 130);
    check_frame(22, 8'h5F, 130);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule